// File: doc/BRIEF.md
# SDRAM Read-to-Write Turnaround Sequencer

This block takes single read and write requests and turns them into command, bank and column outputs for a single-data-rate SDRAM. It also drives the data-mask output and the controller's own data-output enable. A READ can be issued on every clock, to any bank. The block keeps a per-cycle record of which future clocks carry read data from the memory and which of those beats the requester wants. From that record it tags wanted read beats, masks unwanted ones and decides when a WRITE can be issued.

A WRITE can cut a read burst short or follow it directly. It is placed on the first clock after the last wanted read beat, provided the data bus cannot have two drivers. The mask output is raised early enough that the memory mutes any surplus read beats. A WRITE is never issued while read data is still due unless the mask was high on the clock before it. An optional guard leaves one idle clock between the last read beat and the WRITE. Row management, refresh and initialization are not part of this block; banks are taken to be open.

Top module: `sdr_turnaround_seq`

## Requirements
- R1: A request accepted on a clock edge (`req_valid` and `req_ready` high) appears on `cmd` in the next cycle, with its bank and column on `cmd_bank` and `cmd_col`. The encoding is 2'b01 = READ, 2'b10 = WRITE and 2'b00 = idle. Back-to-back READs are issued on consecutive cycles.
- R2: `rd_valid` is high for the wanted beats of a READ issued in cycle R. These are cycles R+CL through R+CL+`req_keep`. CL is 2 when `cl3` is 0 and 3 when it is 1, and `req_keep` holds the wanted beat count minus one.
- R3: A later READ takes over the data bus from its own first data cycle onward. Beats of the earlier burst from that cycle on are dropped and never tagged.
- R4: `dqm` is high two cycles before every read beat that the memory drives but nobody wants. It is never high two cycles before a wanted beat.
- R5: No WRITE is issued in a cycle at or before the last wanted read beat. When no other rule holds it back, it issues in the cycle after that beat.
- R6: With `guard_en` high, at least one cycle without wanted read data separates the last wanted beat from the WRITE.
- R7: A WRITE issued while burst beats are still due after it has `dqm` high in the preceding cycle. While a write waits, `dqm` is raised ahead of time so that this rule does not add delay.
- R8: `req_ready` is always high for a READ. For a WRITE it is low until the turnaround rules allow the WRITE to issue.
- R9: `dq_oe` is high only in the WRITE command cycle, and `dqm` is low in that cycle.
- R10: After reset the outputs `cmd`, `dqm`, `dq_oe` and `rd_valid` are all zero, and a WRITE is ready at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cl3 | input | 1 | CAS latency select: 0 = 2 clocks, 1 = 3 clocks |
| guard_en | input | 1 | Insert an idle cycle before a WRITE that follows read data |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can issue this cycle |
| req_write | input | 1 | 1 = WRITE, 0 = READ |
| req_bank | input | BA_W | Target bank |
| req_col | input | COL_W | Target column |
| req_keep | input | KW | Wanted read beats minus one |
| cmd | output | 2 | Command to the memory |
| cmd_bank | output | BA_W | Bank of the issued command |
| cmd_col | output | COL_W | Column of the issued command |
| dqm | output | 1 | Data mask to the memory |
| dq_oe | output | 1 | Controller data-output enable |
| rd_valid | output | 1 | Current bus cycle carries a wanted read beat |

## Verification
The bench sweeps both latencies, both guard settings, every truncation length of a four-beat burst and seven arrival times for the write. For each combination it computes the exact WRITE cycle and the full mask waveform. This targets the point where the cycle before the WRITE would not have the mask high. A design that ignores that point issues an invalid WRITE. A design that is too careful loses a cycle, and the exact-cycle check catches either error. Separate runs of overlapping READs check that a later burst cuts the earlier one, so that a stale beat tagged or left unmasked shows up as a waveform mismatch. The ready signal is checked on every waiting cycle, because a controller that accepts early would drive the bus against read data.

// File: rtl/sdr_turnaround_seq.sv
module sdr_turnaround_seq #(
  parameter int BA_W = 2,
  parameter int COL_W = 9,
  parameter int BL = 4,
  localparam int KW = (BL > 1) ? $clog2(BL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cl3,
  input  logic             guard_en,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [BA_W-1:0]  req_bank,
  input  logic [COL_W-1:0] req_col,
  input  logic [KW-1:0]    req_keep,
  output logic [1:0]       cmd,
  output logic [BA_W-1:0]  cmd_bank,
  output logic [COL_W-1:0] cmd_col,
  output logic             dqm,
  output logic             dq_oe,
  output logic             rd_valid
);
  localparam int D = BL + 3;
  localparam logic [1:0] C_NOP = 2'b00;
  localparam logic [1:0] C_RD  = 2'b01;
  localparam logic [1:0] C_WR  = 2'b10;

  // index j of each vector describes the bus in cycle now+j
  logic [D-1:0] drv_q, want_q, drv_n, want_n;
  logic dqm_n;
  int lat;

  assign lat = cl3 ? 3 : 2;

  wire want_later = |want_q[D-1:1];
  wire drv_later  = |drv_q[D-1:1];
  wire wr_ok = !want_later && !(guard_en && want_q[0]) && (!drv_later || dqm);

  assign req_ready = !req_write || wr_ok;

  wire acc    = req_valid && req_ready;
  wire acc_rd = acc && !req_write;
  wire acc_wr = acc && req_write;
  wire wr_wait = req_valid && req_write && !wr_ok;

  always_comb begin
    drv_n  = drv_q >> 1;
    want_n = want_q >> 1;
    if (acc_wr) begin
      drv_n  = '0;
      want_n = '0;
    end else if (acc_rd) begin
      for (int j = 2; j < D; j++) begin
        if (j >= lat) begin
          drv_n[j]  = (j < lat + BL);
          want_n[j] = (j <= lat + int'(req_keep));
        end
      end
    end
    dqm_n = !acc_wr && !want_n[2] && (drv_n[2] || wr_wait);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drv_q    <= '0;
      want_q   <= '0;
      dqm      <= 1'b0;
      dq_oe    <= 1'b0;
      cmd      <= C_NOP;
      cmd_bank <= '0;
      cmd_col  <= '0;
    end else begin
      drv_q  <= drv_n;
      want_q <= want_n;
      dqm    <= dqm_n;
      dq_oe  <= acc_wr;
      cmd    <= acc_rd ? C_RD : (acc_wr ? C_WR : C_NOP);
      if (acc) begin
        cmd_bank <= req_bank;
        cmd_col  <= req_col;
      end
    end
  end

  assign rd_valid = want_q[0];
endmodule

// File: rtl/sdr_turnaround_seq_chk.sv
module sdr_turnaround_seq_chk #(
  parameter int D = 7
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cl3,
  input logic         guard_en,
  input logic         req_valid,
  input logic         req_ready,
  input logic         req_write,
  input logic [1:0]   cmd,
  input logic         dqm,
  input logic         dq_oe,
  input logic         rd_valid,
  input logic [D-1:0] drv_q
);
  p_issue_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cmd == ($past(req_write) ? 2'b10 : 2'b01)));

  p_tag_cl2_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b01 && !cl3) |-> ##2 rd_valid);

  p_tag_cl3_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b01 && cl3) |-> ##3 rd_valid);

  p_mask_unwanted_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dqm |-> ##2 !rd_valid);

  p_no_write_on_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b10) |-> !rd_valid);

  p_guard_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b10 && guard_en) |-> !$past(rd_valid));

  p_mask_before_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b10 && (|$past(drv_q[D-1:1]))) |-> $past(dqm));

  p_read_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |-> req_ready);

  p_oe_only_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (cmd == 2'b10 && !dqm));
endmodule

bind sdr_turnaround_seq sdr_turnaround_seq_chk #(.D(BL + 3)) u_chk (
  .clk(clk), .rst_n(rst_n), .cl3(cl3), .guard_en(guard_en),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .cmd(cmd), .dqm(dqm), .dq_oe(dq_oe), .rd_valid(rd_valid), .drv_q(drv_q)
);

// File: tb/test_sdr_turnaround_seq.sv
module test_sdr_turnaround_seq;
  localparam int CLK_P = 10;
  localparam int NC = 40;

  logic clk = 0, rst_n = 0, cl3 = 0, guard_en = 0;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_bank = 0, req_keep = 0;
  logic [8:0] req_col = 0;
  logic req_ready, dqm, dq_oe, rd_valid;
  logic [1:0] cmd, cmd_bank;
  logic [8:0] cmd_col;

  int n_chk = 0, n_err = 0;

  logic [1:0] cmd_a [NC];
  logic [1:0] bank_a [NC];
  logic [8:0] col_a [NC];
  logic dqm_a [NC], oe_a [NC], rv_a [NC], rdy_a [NC];

  always #(CLK_P/2) clk = ~clk;

  sdr_turnaround_seq i_sdr_turnaround_seq (
    .clk(clk), .rst_n(rst_n), .cl3(cl3), .guard_en(guard_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bank(req_bank), .req_col(req_col), .req_keep(req_keep),
    .cmd(cmd), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
    .dqm(dqm), .dq_oe(dq_oe), .rd_valid(rd_valid)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic record(input int t);
    cmd_a[t] = cmd; bank_a[t] = cmd_bank; col_a[t] = cmd_col;
    dqm_a[t] = dqm; oe_a[t] = dq_oe; rv_a[t] = rd_valid; rdy_a[t] = req_ready;
  endtask

  function automatic int exp_w(input int cl, input int g, input int keep, input int p);
    int l = 1 + cl + keep;
    int e = cl + 4;
    int w = (l + 1 + g > p + 1) ? l + 1 + g : p + 1;
    while (!((e < w) || (w - 1 >= p + 1) || (w + 1 <= e))) w++;
    return w;
  endfunction

  // one READ at t=0, WRITE request presented from cycle p until accepted
  task automatic run_rw(input int cl, input int g, input int keep, input int p);
    bit wdone = 0;
    int w, l, e, bad_cmd, bad_dqm, bad_rv, bad_oe, bad_rdy;
    cl3 = (cl == 3); guard_en = g[0];
    idle(12);
    for (int t = 0; t < NC; t++) begin
      if (t == 0) begin
        req_valid = 1; req_write = 0; req_bank = 2'd1; req_col = 9'd20; req_keep = keep[1:0];
      end else if (t >= p && !wdone) begin
        req_valid = 1; req_write = 1; req_bank = 2'd2; req_col = 9'd40;
      end else req_valid = 0;
      #1;
      record(t);
      if (req_valid && req_ready && req_write) wdone = 1;
      @(negedge clk);
    end
    req_valid = 0;
    w = exp_w(cl, g, keep, p);
    l = 1 + cl + keep;
    e = cl + 4;
    chk(cmd_a[1] == 2'b01 && bank_a[1] == 2'd1 && col_a[1] == 9'd20, "R1", "read issue", cmd_a[1], 1);
    if (g != 0) chk(cmd_a[w] == 2'b10, "R6", $sformatf("guarded write cycle %0d", w), cmd_a[w], 2);
    else chk(cmd_a[w] == 2'b10, "R5", $sformatf("write cycle %0d", w), cmd_a[w], 2);
    chk(bank_a[w] == 2'd2 && col_a[w] == 9'd40, "R1", "write address", col_a[w], 40);
    bad_cmd = 0; bad_dqm = 0; bad_rv = 0; bad_oe = 0; bad_rdy = 0;
    for (int c = 0; c < NC; c++) begin
      int b = c + 2;
      bit wnt = (b >= 1 + cl) && (b <= l);
      bit drv = (b >= 1 + cl) && (b <= e);
      bit xd = (c >= 1 && c < w) && ((drv && !wnt) || (c - 1 >= p && !wnt));
      bit xc = (c != 1 && c != w) ? (cmd_a[c] != 2'b00) : 1'b0;
      if (xc) bad_cmd++;
      if (dqm_a[c] != xd) bad_dqm++;
      if (rv_a[c] != (c >= 1 + cl && c <= l)) bad_rv++;
      if (oe_a[c] != (c == w)) bad_oe++;
      if (c >= p && c <= w - 2 && rdy_a[c]) bad_rdy++;
    end
    chk(bad_cmd == 0, "R1", "stray commands", bad_cmd, 0);
    chk(bad_rv == 0, "R2", "tagged beat mismatches", bad_rv, 0);
    chk(bad_dqm == 0, "R4", "mask waveform mismatches", bad_dqm, 0);
    if (e >= w) chk(dqm_a[w-1] == 1'b1, "R7", "mask before write", dqm_a[w-1], 1);
    chk(bad_oe == 0 && dqm_a[w] == 1'b0, "R9", "oe mismatches", bad_oe, 0);
    chk(bad_rdy == 0 && rdy_a[w-1] == 1'b1, "R8", "ready mismatches", bad_rdy, 0);
  endtask

  // five consecutive READs, each cutting the previous burst
  task automatic run_rd(input int cl);
    int keeps [5] = '{3, 1, 3, 0, 2};
    int bad_cmd = 0, bad_rv = 0, bad_dqm = 0, bad_oe = 0, bad_rdy = 0;
    cl3 = (cl == 3); guard_en = 0;
    idle(12);
    for (int t = 0; t < NC; t++) begin
      if (t < 5) begin
        req_valid = 1; req_write = 0; req_bank = t[1:0]; req_col = 9'(t * 8); req_keep = keeps[t][1:0];
      end else req_valid = 0;
      #1;
      record(t);
      if (t < 5 && !req_ready) bad_rdy++;
      @(negedge clk);
    end
    req_valid = 0;
    for (int c = 0; c < NC; c++) begin
      bit xw = 0, xv = 0, xdw = 0, xdv = 0;
      for (int i = 0; i < 5; i++) begin
        int k = c - (i + 1) - cl;
        int k2 = c + 2 - (i + 1) - cl;
        if (k >= 0) begin xv = (k < 4); xw = (k < 4) && (k <= keeps[i]); end
        if (k2 >= 0) begin xdv = (k2 < 4); xdw = (k2 < 4) && (k2 <= keeps[i]); end
      end
      if (c >= 1 && c <= 5) begin
        if (cmd_a[c] != 2'b01 || bank_a[c] != 2'(c - 1) || col_a[c] != 9'((c - 1) * 8)) bad_cmd++;
      end else if (cmd_a[c] != 2'b00) bad_cmd++;
      if (rv_a[c] != xw) bad_rv++;
      if (dqm_a[c] != (xdv && !xdw)) bad_dqm++;
      if (oe_a[c]) bad_oe++;
      if (xv && 0) bad_oe++;
    end
    chk(bad_cmd == 0, "R1", "back-to-back read commands", bad_cmd, 0);
    chk(bad_rv == 0, "R3", "cut burst tag mismatches", bad_rv, 0);
    chk(bad_dqm == 0, "R4", "cut burst mask mismatches", bad_dqm, 0);
    chk(bad_oe == 0, "R9", "oe during reads", bad_oe, 0);
    chk(bad_rdy == 0, "R8", "read not ready", bad_rdy, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(cmd == 2'b00, "R10", "cmd after reset", cmd, 0);
    chk(!dqm && !dq_oe && !rd_valid, "R10", "mask/oe/valid after reset", {dqm, dq_oe, rd_valid}, 0);
    req_write = 1;
    #1;
    chk(req_ready == 1'b1, "R10", "write ready when idle", req_ready, 1);
    req_write = 0;
    @(negedge clk);
    for (int cl = 2; cl <= 3; cl++) begin
      run_rd(cl);
      for (int g = 0; g < 2; g++)
        for (int keep = 0; keep < 4; keep++)
          for (int p = 1; p <= 7; p++)
            run_rw(cl, g, keep, p);
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule